// File: doc/BRIEF.md
# SD Card Command Issuer

This block turns a host write of a 32-bit command word into one request toward a card-side command port. The request carries a 6-bit command index and a 32-bit argument. The block then waits for the card's reply. A reply can be a short (4-byte) response, a long (16-byte) response or an error indication. The block judges the reply against the response type the command word asked for. It assembles accepted reply bytes into four 32-bit response words, most significant byte first, and records the outcome in three sticky status flags: command sent, response end and command timeout.

The host writes the argument first and then the command word with its enable bit set. The block handshakes the request out using valid and ready, and accepts one reply. It then clears the enable bit in its command readback. One cycle later it pulses a start signal toward the data-transfer engine. A command word that also carries the pending flag is not issued: only its enable bit is dropped. Serial line framing, CRC and interrupt-wait behaviour belong elsewhere.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset the command and argument readbacks, all four response words and all status flags are zero. `busy_o`, `req_valid_o` and `data_kick_o` are low.
- R2: A command write while idle, with bit 10 (enable) set and bit 9 (pending) clear, raises `req_valid_o` in the next cycle. `req_index_o` equals command bits 5:0 and `req_arg_o` equals the argument. All three hold stable until `req_ready_i` is seen high.
- R3: A command write with bits 10 and 9 both set issues no request and produces no status and no data kick. The readback shows bit 10 cleared in the next cycle and keeps the other bits as written.
- R4: When command bit 6 (response expected) is clear and the reply has no error flag, completion sets only the sent flag. The response words are left unchanged.
- R5: An accepted reply with a length code of 4 puts bytes 0..3 into word 0, with byte 0 in bits 31:24, and clears words 1..3. The response-end flag is set.
- R6: An accepted reply with a length code of 16 fills words 0..3 from bytes 0..15, most significant byte first, and forces bit 0 of word 3 to zero. The response-end flag is set.
- R7: The timeout flag is set, and the response words are left unchanged, in any of these cases: the reply's error flag is set; or a response is expected and the length code is 0, is 4 while command bit 7 (long) is set, or is anything other than 4 or 16.
- R8: On completion, whatever the outcome, `busy_o` falls and command readback bit 10 reads zero.
- R9: `data_kick_o` is high for exactly one cycle, starting one cycle after the completion edge.
- R10: Status flags stay set until cleared. Bit 0 of `stat_clr_i` clears sent, bit 1 clears response end and bit 2 clears timeout. A clear bit leaves the other flags as they were.
- R11: Command and argument writes made while `busy_o` is high are ignored.
- R12: Command bit 8 (interrupt wait) has no effect, and a command with it set is issued normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word |
| arg_wr_i | input | 1 | Argument write strobe |
| arg_wdata_i | input | 32 | Argument value |
| stat_clr_i | input | 3 | Status clear mask (sent, response end, timeout) |
| cmd_o | output | 32 | Command readback |
| arg_o | output | 32 | Argument readback |
| busy_o | output | 1 | Command in flight |
| req_valid_o | output | 1 | Request valid toward card port |
| req_ready_i | input | 1 | Card port accepts request |
| req_index_o | output | 6 | Command index |
| req_arg_o | output | 32 | Command argument |
| rsp_valid_i | input | 1 | Reply valid |
| rsp_err_i | input | 1 | Reply error flag |
| rsp_len_i | input | 5 | Reply length in bytes |
| rsp_data_i | input | 128 | Reply bytes, byte 0 in bits 127:120 |
| resp_o | output | 128 | Response words, word j in bits 32j+31:32j |
| stat_sent_o | output | 1 | Command sent flag |
| stat_rspend_o | output | 1 | Response end flag |
| stat_timeout_o | output | 1 | Command timeout flag |
| data_kick_o | output | 1 | Start pulse toward data engine |

## Verification
Each reply pattern is paired with a command type, so that every branch of the length check is taken. A no-response command with a clean reply and with an error flag separates the sent path from the error path. Short and long replies with distinct bytes in every position expose byte-order and word-placement faults. A 16-byte reply to a short request shows that placement follows the returned length. The three rejected lengths (0, 4 on a long request, 7) each prove that the response words keep the earlier long result. Pending commands, interrupt-flagged commands, writes made while busy and partial status clears cover the control paths.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  // command word control fields (bit 8, interrupt wait, is decoded nowhere)
  localparam int CMD_RSP_BIT  = 6;
  localparam int CMD_LONG_BIT = 7;
  localparam int CMD_PEND_BIT = 9;
  localparam int CMD_EN_BIT   = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } cmd_state_e;

  // bit 0 sent, bit 1 response end, bit 2 timeout
  typedef struct packed {
    logic timeout;
    logic rspend;
    logic sent;
  } cmd_stat_t;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int ARG_W = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             arg_wr_i,
  input  logic [ARG_W-1:0] arg_wdata_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic [ARG_W-1:0] arg_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [IDX_W-1:0] req_index_o,
  output logic [ARG_W-1:0] req_arg_o,
  input  logic             rsp_valid_i,
  output logic             rsp_exp_o,
  output logic             rsp_long_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             data_kick_o
);
  cmd_state_e       state_q;
  logic [CMD_W-1:0] cmd_q;
  logic [ARG_W-1:0] arg_q;
  logic             done_q, kick_q;
  logic             idle, start, park;

  assign idle  = (state_q == ST_IDLE);
  assign start = idle && cmd_wr_i && cmd_wdata_i[CMD_EN_BIT] && !cmd_wdata_i[CMD_PEND_BIT];
  assign park  = cmd_wdata_i[CMD_EN_BIT] && cmd_wdata_i[CMD_PEND_BIT];
  assign accept_o = (state_q == ST_WAIT) && rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      arg_q   <= '0;
      done_q  <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      done_q <= accept_o;
      kick_q <= done_q;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_wr_i) begin
            cmd_q <= cmd_wdata_i;
            if (park) cmd_q[CMD_EN_BIT] <= 1'b0;
          end
          if (arg_wr_i) arg_q <= arg_wdata_i;
          if (start) state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid_i) begin
            state_q <= ST_IDLE;
            cmd_q[CMD_EN_BIT] <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o       = cmd_q;
  assign arg_o       = arg_q;
  assign req_valid_o = (state_q == ST_ISSUE);
  assign req_index_o = cmd_q[IDX_W-1:0];
  assign req_arg_o   = arg_q;
  assign rsp_exp_o   = cmd_q[CMD_RSP_BIT];
  assign rsp_long_o  = cmd_q[CMD_LONG_BIT];
  assign busy_o      = !idle;
  assign data_kick_o = kick_q;

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_index_o) && $stable(req_arg_o));
  p_pending_no_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && cmd_wr_i && cmd_wdata_i[CMD_PEND_BIT] |=> !req_valid_o && !cmd_o[CMD_EN_BIT]);
  p_enable_low_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !cmd_q[CMD_EN_BIT]);
  p_kick_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> data_kick_o);
  p_kick_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_kick_o |=> !data_kick_o);
  p_busy_write_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ISSUE) |=> $stable(arg_o));
endmodule

// File: rtl/sd_rsp_check.sv
module sd_rsp_check
  import sd_cmd_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  parameter int WORD_W    = 32,
  parameter int LEN_W     = $clog2(RSP_BYTES + 1)
) (
  input  logic                                   rsp_exp_i,
  input  logic                                   rsp_long_i,
  input  logic                                   rsp_err_i,
  input  logic [LEN_W-1:0]                       rsp_len_i,
  input  logic [RSP_BYTES*8-1:0]                 rsp_data_i,
  output cmd_stat_t                              stat_o,
  output logic                                   wr_words_o,
  output logic [RSP_BYTES*8/WORD_W-1:0][WORD_W-1:0] words_o
);
  localparam int N_WORDS     = RSP_BYTES * 8 / WORD_W;
  localparam int SHORT_BYTES = WORD_W / 8;
  localparam int TOT_W       = RSP_BYTES * 8;

  logic is_short, is_long, len_ok;

  assign is_short = (rsp_len_i == LEN_W'(SHORT_BYTES));
  assign is_long  = (rsp_len_i == LEN_W'(RSP_BYTES));
  assign len_ok   = (is_short && !rsp_long_i) || is_long;

  always_comb begin
    stat_o     = '0;
    wr_words_o = 1'b0;
    if (rsp_err_i) begin
      stat_o.timeout = 1'b1;
    end else if (!rsp_exp_i) begin
      stat_o.sent = 1'b1;
    end else if (len_ok) begin
      stat_o.rspend = 1'b1;
      wr_words_o    = 1'b1;
    end else begin
      stat_o.timeout = 1'b1;
    end
  end

  // word placement follows the returned length, byte 0 most significant
  for (genvar j = 0; j < N_WORDS; j++) begin : g_word
    if (j == 0) begin : g_first
      assign words_o[j] = rsp_data_i[TOT_W-1 -: WORD_W];
    end else if (j == N_WORDS - 1) begin : g_last
      assign words_o[j] = is_long ?
        {rsp_data_i[TOT_W-1-j*WORD_W -: WORD_W-1], 1'b0} : '0;
    end else begin : g_mid
      assign words_o[j] = is_long ? rsp_data_i[TOT_W-1-j*WORD_W -: WORD_W] : '0;
    end
  end
endmodule

// File: rtl/sd_rsp_regs.sv
module sd_rsp_regs
  import sd_cmd_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             upd_i,
  input  cmd_stat_t                        stat_i,
  input  logic                             wr_words_i,
  input  logic [N_WORDS-1:0][WORD_W-1:0]   words_i,
  input  logic [2:0]                       clr_i,
  output logic [N_WORDS-1:0][WORD_W-1:0]   words_o,
  output cmd_stat_t                        stat_o
);
  logic [N_WORDS-1:0][WORD_W-1:0] words_q;
  cmd_stat_t                      stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
      stat_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | (upd_i ? stat_i : cmd_stat_t'('0));
      if (upd_i && wr_words_i) words_q <= words_i;
    end
  end

  assign words_o = words_q;
  assign stat_o  = stat_q;

  p_one_outcome_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> $onehot(stat_i));
  p_word3_lsb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && wr_words_i |=> !words_o[N_WORDS-1][0]);
  p_timeout_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && stat_i.timeout |=> $stable(words_o) && stat_o.timeout);
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o.sent && !clr_i[0] |=> stat_o.sent);
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
  import sd_cmd_pkg::*;
#(
  parameter int CMD_W     = 32,
  parameter int ARG_W     = 32,
  parameter int IDX_W     = 6,
  parameter int RSP_BYTES = 16,
  parameter int WORD_W    = 32,
  parameter int LEN_W     = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_wr_i,
  input  logic [CMD_W-1:0]       cmd_wdata_i,
  input  logic                   arg_wr_i,
  input  logic [ARG_W-1:0]       arg_wdata_i,
  input  logic [2:0]             stat_clr_i,
  output logic [CMD_W-1:0]       cmd_o,
  output logic [ARG_W-1:0]       arg_o,
  output logic                   busy_o,
  output logic                   req_valid_o,
  input  logic                   req_ready_i,
  output logic [IDX_W-1:0]       req_index_o,
  output logic [ARG_W-1:0]       req_arg_o,
  input  logic                   rsp_valid_i,
  input  logic                   rsp_err_i,
  input  logic [LEN_W-1:0]       rsp_len_i,
  input  logic [RSP_BYTES*8-1:0] rsp_data_i,
  output logic [RSP_BYTES*8-1:0] resp_o,
  output logic                   stat_sent_o,
  output logic                   stat_rspend_o,
  output logic                   stat_timeout_o,
  output logic                   data_kick_o
);
  localparam int N_WORDS = RSP_BYTES * 8 / WORD_W;

  logic                           rsp_exp, rsp_long, accept, wr_words;
  cmd_stat_t                      chk_stat, stat_q;
  logic [N_WORDS-1:0][WORD_W-1:0] chk_words, words_q;

  sd_cmd_ctrl #(.CMD_W(CMD_W), .ARG_W(ARG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_wr_i    (cmd_wr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .arg_wr_i    (arg_wr_i),
    .arg_wdata_i (arg_wdata_i),
    .cmd_o       (cmd_o),
    .arg_o       (arg_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_index_o (req_index_o),
    .req_arg_o   (req_arg_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_exp_o   (rsp_exp),
    .rsp_long_o  (rsp_long),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .data_kick_o (data_kick_o)
  );

  sd_rsp_check #(.RSP_BYTES(RSP_BYTES), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_check (
    .rsp_exp_i  (rsp_exp),
    .rsp_long_i (rsp_long),
    .rsp_err_i  (rsp_err_i),
    .rsp_len_i  (rsp_len_i),
    .rsp_data_i (rsp_data_i),
    .stat_o     (chk_stat),
    .wr_words_o (wr_words),
    .words_o    (chk_words)
  );

  sd_rsp_regs #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (accept),
    .stat_i     (chk_stat),
    .wr_words_i (wr_words),
    .words_i    (chk_words),
    .clr_i      (stat_clr_i),
    .words_o    (words_q),
    .stat_o     (stat_q)
  );

  assign resp_o         = words_q;
  assign stat_sent_o    = stat_q.sent;
  assign stat_rspend_o  = stat_q.rspend;
  assign stat_timeout_o = stat_q.timeout;

  p_done_clears_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !busy_o && !cmd_o[CMD_EN_BIT]);
endmodule

// File: tb/tb_sd_cmd_issuer.sv
`timescale 1ns/1ps
module tb_sd_cmd_issuer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0, arg_wr = 1'b0;
  logic [31:0]  cmd_wdata = '0, arg_wdata = '0;
  logic [2:0]   stat_clr = '0;
  logic [31:0]  cmd_o, arg_o;
  logic         busy, req_valid, req_ready = 1'b0;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic [127:0] resp;
  logic         st_sent, st_rspend, st_to, kick;

  int n_cmp = 0, n_bad = 0;
  logic [127:0] model_words = '0;
  logic [127:0] q_words[$];
  logic [2:0]   q_stat[$];
  string        q_tag[$];
  bit           busy_d = 1'b0;

  always #4 clk = ~clk;

  sd_cmd_issuer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .arg_wr_i(arg_wr), .arg_wdata_i(arg_wdata),
    .stat_clr_i(stat_clr), .cmd_o(cmd_o), .arg_o(arg_o), .busy_o(busy),
    .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_index_o(req_index), .req_arg_o(req_arg),
    .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err), .rsp_len_i(rsp_len),
    .rsp_data_i(rsp_data), .resp_o(resp),
    .stat_sent_o(st_sent), .stat_rspend_o(st_rspend), .stat_timeout_o(st_to),
    .data_kick_o(kick)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [127:0] d, input int k);
    return d[127-8*k -: 8];
  endfunction

  // expected outcome from the requirements: {timeout, rspend, sent}
  task automatic predict(input logic [31:0] cmd, input logic [4:0] len, input bit err,
                         input logic [127:0] d, input string tag);
    logic [2:0]   st;
    logic [127:0] w;
    w = model_words;
    if (err) st = 3'b100;
    else if (!cmd[6]) st = 3'b001;
    else if ((len == 5'd4 && !cmd[7]) || len == 5'd16) begin
      st = 3'b010;
      w = '0;
      for (int j = 0; j < 4; j++) begin
        if (j == 0 || len == 5'd16)
          for (int b = 0; b < 4; b++) w[32*j + 24 - 8*b +: 8] = byte_of(d, 4*j + b);
      end
      w[96] = 1'b0;
    end else st = 3'b100;
    model_words = w;
    q_words.push_back(w);
    q_stat.push_back(st);
    q_tag.push_back(tag);
  endtask

  // monitor: compare on every completion
  always @(negedge clk) begin
    if (rst_n && busy_d && !busy) begin
      if (q_stat.size() == 0) chk(1'b0, "R8 unexpected completion", 128'd1, 128'd0);
      else begin
        logic [127:0] ew;
        logic [2:0]   es;
        string        t;
        ew = q_words.pop_front();
        es = q_stat.pop_front();
        t  = q_tag.pop_front();
        chk(resp == ew, t, resp, ew);
        chk({st_to, st_rspend, st_sent} == es, {t, " status"}, {125'd0, st_to, st_rspend, st_sent}, {125'd0, es});
      end
    end
    busy_d = busy;
  end

  task automatic run_cmd(input logic [31:0] cmd, input logic [31:0] arg, input logic [4:0] len,
                         input bit err, input logic [127:0] d, input bit busy_wr, input string tag);
    @(negedge clk) stat_clr = 3'b111;
    @(negedge clk) stat_clr = 3'b000;
    predict(cmd, len, err, d, tag);
    arg_wr = 1'b1; arg_wdata = arg; cmd_wr = 1'b1; cmd_wdata = cmd;
    @(negedge clk) arg_wr = 1'b0; cmd_wr = 1'b0;
    chk(req_valid && req_index == cmd[5:0] && req_arg == arg, "R2 request fields",
        {89'd0, req_valid, req_index, req_arg}, {89'd0, 1'b1, cmd[5:0], arg});
    @(negedge clk);
    chk(req_valid && req_index == cmd[5:0] && req_arg == arg, "R2 request held",
        {89'd0, req_valid, req_index, req_arg}, {89'd0, 1'b1, cmd[5:0], arg});
    req_ready = 1'b1;
    @(negedge clk) req_ready = 1'b0;
    chk(!req_valid && busy, "R2 request retired", {126'd0, req_valid, busy}, 128'd1);
    if (busy_wr) begin
      cmd_wr = 1'b1; cmd_wdata = 32'h0000_0415; arg_wr = 1'b1; arg_wdata = 32'hDEAD_0000;
      @(negedge clk) cmd_wr = 1'b0; arg_wr = 1'b0;
    end
    @(negedge clk);
    rsp_valid = 1'b1; rsp_len = len; rsp_err = err; rsp_data = d;
    @(negedge clk) rsp_valid = 1'b0;
    chk(!busy && cmd_o == (cmd & ~32'h400), "R8 enable cleared", {96'd0, cmd_o}, {96'd0, cmd & ~32'h400});
    chk(arg_o == arg, "R11 argument kept", {96'd0, arg_o}, {96'd0, arg});
    chk(!kick, "R9 kick not yet", {127'd0, kick}, 128'd0);
    @(negedge clk);
    chk(kick, "R9 kick pulse", {127'd0, kick}, 128'd1);
    @(negedge clk);
    chk(!kick, "R9 kick single", {127'd0, kick}, 128'd0);
  endtask

  localparam logic [127:0] PAT_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
  localparam logic [127:0] PAT_B = 128'hA1B2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F91;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_o == 0 && arg_o == 0 && resp == 0, "R1 reset registers", resp | {cmd_o, arg_o}, 128'd0);
    chk(!busy && !req_valid && !kick && !st_sent && !st_rspend && !st_to, "R1 reset outputs",
        {122'd0, busy, req_valid, kick, st_sent, st_rspend, st_to}, 128'd0);

    run_cmd(32'h0000_0400 | 32'd0,  32'h0000_0000, 5'd0,  1'b0, PAT_A, 1'b0, "R4 no response sent");
    run_cmd(32'h0000_0440 | 32'd17, 32'h1234_5678, 5'd4,  1'b0, PAT_A, 1'b0, "R5 short response");
    run_cmd(32'h0000_04C0 | 32'd2,  32'hCAFE_0001, 5'd16, 1'b0, PAT_A, 1'b0, "R6 long response");
    run_cmd(32'h0000_0440 | 32'd9,  32'h0000_0009, 5'd4,  1'b1, PAT_B, 1'b0, "R7 error flag");
    run_cmd(32'h0000_0440 | 32'd13, 32'h0000_000D, 5'd0,  1'b0, PAT_B, 1'b0, "R7 zero length");
    run_cmd(32'h0000_04C0 | 32'd10, 32'h0000_000A, 5'd4,  1'b0, PAT_B, 1'b0, "R7 short on long");
    run_cmd(32'h0000_0440 | 32'd55, 32'h0000_0037, 5'd7,  1'b0, PAT_B, 1'b0, "R7 odd length");
    run_cmd(32'h0000_0400 | 32'd63, 32'hFFFF_FFFF, 5'd16, 1'b1, PAT_B, 1'b0, "R7 error no response");
    run_cmd(32'h0000_0440 | 32'd8,  32'h0000_01AA, 5'd16, 1'b0, PAT_B, 1'b0, "R6 long on short");
    run_cmd(32'h0000_0540 | 32'd3,  32'h0BAD_F00D, 5'd4,  1'b0, PAT_A, 1'b0, "R12 interrupt bit ignored");
    run_cmd(32'h0000_0440 | 32'd41, 32'h5555_AAAA, 5'd4,  1'b0, PAT_B, 1'b1, "R11 busy writes ignored");

    // R3: pending command is parked
    @(negedge clk) stat_clr = 3'b111;
    @(negedge clk) stat_clr = 3'b000; cmd_wr = 1'b1; cmd_wdata = 32'h0000_0607;
    @(negedge clk) cmd_wr = 1'b0;
    chk(cmd_o == 32'h0000_0207 && !busy && !req_valid, "R3 pending parked",
        {95'd0, busy | req_valid, cmd_o}, {96'd0, 32'h0000_0207});
    repeat (2) begin
      @(negedge clk);
      chk(!kick && !req_valid && !st_sent && !st_rspend && !st_to, "R3 pending quiet",
          {123'd0, kick, req_valid, st_sent, st_rspend, st_to}, 128'd0);
    end

    // R10: sticky flags and selective clear
    run_cmd(32'h0000_0400 | 32'd1, 32'h0000_0001, 5'd0, 1'b0, PAT_A, 1'b0, "R10 sent for sticky test");
    repeat (3) @(negedge clk);
    chk(st_sent, "R10 sent sticky", {127'd0, st_sent}, 128'd1);
    stat_clr = 3'b110;
    @(negedge clk) stat_clr = 3'b000;
    chk(st_sent, "R10 other clears leave sent", {127'd0, st_sent}, 128'd1);
    stat_clr = 3'b001;
    @(negedge clk) stat_clr = 3'b000;
    chk(!st_sent, "R10 sent cleared", {127'd0, st_sent}, 128'd0);

    @(negedge clk);
    chk(q_stat.size() == 0, "R8 all completions seen", 128'(q_stat.size()), 128'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 128'd1, 128'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule